// File: doc/BRIEF.md
# Multichannel DAC double-buffer update controller

This block sits on the register side of a bank of 12-bit analog output channels. Each channel holds a pre-load register that the host fills one byte at a time, and an output register whose word drives the converter. The host uses a byte-wide bus with a 5-bit offset and separate write and read strobes. Channel n takes its low byte at offset 2n and its high byte at offset 2n+1.

A read at one of a set of fixed offsets acts as a command rather than returning data. These commands switch the block between automatic update, where a channel's output follows its high-byte write, and simultaneous update, where all outputs change together on a command. They also turn the timer-driven update and the interrupt on or off, and they set or clear a global output-restrict flag. A timer tick input loads every output register when timed update is enabled. The same tick can raise a level interrupt request, which stays set until the host clears it.

Top module: `dac_update_ctrl`

## Requirements
- R1: A write at offset 2n loads bits 7..0 of channel n's pre-load register. A write at offset 2n+1 loads bits 11..8 from the low nibble of the data byte, and the upper nibble has no effect. Channel n's output word appears on dac_out[12n+11:12n].
- R2: In automatic mode, a high-byte write loads that channel's output register in the same clock edge and leaves every other channel unchanged. A low-byte write changes no output.
- R3: A read at offset 0x00 enters simultaneous mode. A read at offset 0x02 enters automatic mode. Neither read changes any output, and in simultaneous mode a byte write changes no output.
- R4: A read at offset 0x08 copies every pre-load register to its output register and leaves the block in simultaneous mode. A read at offset 0x0A does the same copy and leaves the block in automatic mode.
- R5: A read at offset 0x05 enables timed update and a read at offset 0x06 disables it. While timed update is enabled, a tick loads all output registers. While it is disabled, a tick changes no output.
- R6: A read at offset 0x03 enables the interrupt and clears a pending request. A read at offset 0x04 disables the interrupt and keeps any pending request. A tick sets irq only while the interrupt is enabled, and irq then stays high until it is cleared.
- R7: A read at offset 0x0E sets out_limit and a read at offset 0x0F clears it. Neither read changes any output word.
- R8: After reset the block is in simultaneous mode, out_limit is 1, irq is 0, timed update and the interrupt are disabled, and every output word is 0.
- R9: A read at any offset not listed in R3 to R7 has no effect. With NCH=8, writes at offsets 16 to 31 change no output.
- R10: Any output load uses the pre-load value as it stands after that cycle's byte write, so a high-byte write and a tick in the same cycle load the new word. If a tick sets irq in the same cycle as a clearing read, irq ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ofs | input | 5 | Register offset of the current access |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Byte write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; at a command offset it performs the command |
| tick | input | 1 | Timer tick, one cycle per tick |
| dac_out | output | NCH*12 | Output register words, channel n at bits 12n+11..12n |
| out_limit | output | 1 | Restrict-output flag |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. A channel's high-byte write can meet a timer tick that loads all channels, and a tick that sets the interrupt can meet the read that clears it. The bench drives the high-byte write and the tick in one cycle and expects the channel to show the newly written word, while the other channels show their pre-load contents. In a separate cycle it drives the tick together with the acknowledging read and expects irq to stay high afterwards. An instance with eight channels covers the writes at offsets that lie past the last channel.

// File: rtl/dacu_pkg.sv
// Shared constants and the command type for the DAC update controller.
// Assumes a 5-bit byte offset space and 8-bit bus data.
package dacu_pkg;
    localparam int OFS_W  = 5;
    localparam int BYTE_W = 8;

    localparam logic [OFS_W-1:0] OFS_SIM_ON   = 5'h00;
    localparam logic [OFS_W-1:0] OFS_SIM_OFF  = 5'h02;
    localparam logic [OFS_W-1:0] OFS_IRQ_ON   = 5'h03;
    localparam logic [OFS_W-1:0] OFS_IRQ_OFF  = 5'h04;
    localparam logic [OFS_W-1:0] OFS_TMR_ON   = 5'h05;
    localparam logic [OFS_W-1:0] OFS_TMR_OFF  = 5'h06;
    localparam logic [OFS_W-1:0] OFS_UPD_HOLD = 5'h08;
    localparam logic [OFS_W-1:0] OFS_UPD_AUTO = 5'h0A;
    localparam logic [OFS_W-1:0] OFS_LIM_ON   = 5'h0E;
    localparam logic [OFS_W-1:0] OFS_LIM_OFF  = 5'h0F;

    typedef struct packed {
        logic sim_on;
        logic sim_off;
        logic irq_on;
        logic irq_off;
        logic tmr_on;
        logic tmr_off;
        logic upd_hold;
        logic upd_auto;
        logic lim_on;
        logic lim_off;
    } dacu_cmd_t;
endpackage

// File: rtl/dacu_cmd_dec.sv
// Turns a read strobe at a command offset into a one-cycle command pulse.
// Assumes a read at any other offset has no effect.
module dacu_cmd_dec
    import dacu_pkg::*;
(
    input  logic             rd,
    input  logic [OFS_W-1:0] ofs,
    output dacu_cmd_t        cmd
);
    // Decode the read offset into a single command field.
    always_comb begin
        cmd = '0;
        if (rd) begin
            case (ofs)
                OFS_SIM_ON:   cmd.sim_on   = 1'b1;
                OFS_SIM_OFF:  cmd.sim_off  = 1'b1;
                OFS_IRQ_ON:   cmd.irq_on   = 1'b1;
                OFS_IRQ_OFF:  cmd.irq_off  = 1'b1;
                OFS_TMR_ON:   cmd.tmr_on   = 1'b1;
                OFS_TMR_OFF:  cmd.tmr_off  = 1'b1;
                OFS_UPD_HOLD: cmd.upd_hold = 1'b1;
                OFS_UPD_AUTO: cmd.upd_auto = 1'b1;
                OFS_LIM_ON:   cmd.lim_on   = 1'b1;
                OFS_LIM_OFF:  cmd.lim_off  = 1'b1;
                default:      cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/dacu_mode_ctrl.sv
// Holds the update mode, the timer and interrupt enables, the restrict flag
// and the interrupt request. It produces the all-channel load strobe.
// Assumes command pulses last one cycle.
module dacu_mode_ctrl
    import dacu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dacu_cmd_t cmd,
    input  logic      tick,
    output logic      sim_mode,
    output logic      glob_load,
    output logic      lim_q,
    output logic      irq_q
);
    logic tmr_en_q;
    logic irq_en_q;
    logic irq_set;

    // Global load from the two update commands or from an enabled tick.
    assign glob_load = cmd.upd_hold | cmd.upd_auto | (tick & tmr_en_q);
    assign irq_set   = tick & irq_en_q;

    // Mode, enable and restrict registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sim_mode <= 1'b1;
            tmr_en_q <= 1'b0;
            irq_en_q <= 1'b0;
            lim_q    <= 1'b1;
        end else begin
            if (cmd.sim_on || cmd.upd_hold)      sim_mode <= 1'b1;
            else if (cmd.sim_off || cmd.upd_auto) sim_mode <= 1'b0;
            if (cmd.tmr_on)       tmr_en_q <= 1'b1;
            else if (cmd.tmr_off) tmr_en_q <= 1'b0;
            if (cmd.irq_on)       irq_en_q <= 1'b1;
            else if (cmd.irq_off) irq_en_q <= 1'b0;
            if (cmd.lim_on)       lim_q <= 1'b1;
            else if (cmd.lim_off) lim_q <= 1'b0;
        end
    end

    // Level interrupt request: a set wins over the acknowledge in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_set | (irq_q & ~cmd.irq_on);
    end

    a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sim_mode && lim_q && !irq_q));
    a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !cmd.irq_on) |=> irq_q);
    a_r7_limit_on: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.lim_on |=> lim_q);
    a_r4_auto_after: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.upd_auto |=> !sim_mode);
endmodule

// File: rtl/dacu_channel.sv
// One channel: a byte-written pre-load register and an output register.
// Assumes DW is greater than 8 and at most 16. The pre-load register is not
// reset, and the output register resets to zero.
module dacu_channel
    import dacu_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic              auto_mode,
    input  logic              glob_load,
    output logic [DW-1:0]     out_q
);
    localparam int HI_W = DW - BYTE_W;

    logic [BYTE_W-1:0] pre_lo, pre_lo_nxt;
    logic [HI_W-1:0]   pre_hi, pre_hi_nxt;
    logic              load;

    // Merged pre-load value after this cycle's byte write.
    always_comb begin
        pre_lo_nxt = we_lo ? wdata : pre_lo;
        pre_hi_nxt = we_hi ? wdata[HI_W-1:0] : pre_hi;
    end

    assign load = glob_load | (we_hi & auto_mode);

    // Pre-load storage, left uncleared by reset.
    always_ff @(posedge clk) begin
        pre_lo <= pre_lo_nxt;
        pre_hi <= pre_hi_nxt;
    end

    // Output register loads the merged pre-load word.
    always_ff @(posedge clk) begin
        if (!rst_n)    out_q <= '0;
        else if (load) out_q <= {pre_hi_nxt, pre_lo_nxt};
    end

    a_r2_hold_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_load && !(we_hi && auto_mode)) |=> $stable(out_q));
    a_r1_hi_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (we_hi && auto_mode) |=> (out_q[DW-1:BYTE_W] == $past(wdata[HI_W-1:0])));
endmodule

// File: rtl/dac_update_ctrl.sv
// Top of the DAC double-buffer update controller. It decodes byte writes
// to the channels and read commands to the mode controller. Assumes
// NCH is at most 16 so that the channels fit in offsets 0..31.
module dac_update_ctrl
    import dacu_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              tick,
    output logic [NCH*DW-1:0] dac_out,
    output logic              out_limit,
    output logic              irq
);
    localparam int IDX_W = OFS_W - 1;

    dacu_cmd_t cmd;
    logic      sim_mode;
    logic      glob_load;

    dacu_cmd_dec u_dec (
        .rd  (bus_rd),
        .ofs (bus_ofs),
        .cmd (cmd)
    );

    dacu_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .tick      (tick),
        .sim_mode  (sim_mode),
        .glob_load (glob_load),
        .lim_q     (out_limit),
        .irq_q     (irq)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;
        // Channel select from the upper offset bits.
        assign sel = bus_wr && (bus_ofs[OFS_W-1:1] == IDX_W'(i));

        dacu_channel #(.DW(DW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wdata     (bus_wdata),
            .we_lo     (sel && !bus_ofs[0]),
            .we_hi     (sel && bus_ofs[0]),
            .auto_mode (!sim_mode),
            .glob_load (glob_load),
            .out_q     (dac_out[i*DW +: DW])
        );
    end
endmodule

// File: tb/dac_update_ctrl_test.sv
module dac_update_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int DW  = 12;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  ofs;
        logic [7:0]  data;
        logic [3:0]  ch;
        logic [11:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 5'h08, 8'h00, 4'd5,  12'h515, 4'd4},  // R4 hold update
        '{OP_WR, 5'h0A, 8'h77, 4'd5,  12'h515, 4'd3},  // R3 no change in sim
        '{OP_WR, 5'h0B, 8'h3C, 4'd5,  12'h515, 4'd3},  // R3
        '{OP_RD, 5'h02, 8'h00, 4'd5,  12'h515, 4'd3},  // R3 leave sim, no update
        '{OP_WR, 5'h0B, 8'hF2, 4'd5,  12'h277, 4'd1},  // R1 upper nibble ignored
        '{OP_WR, 5'h00, 8'h99, 4'd0,  12'h010, 4'd2},  // R2 low byte no load
        '{OP_WR, 5'h01, 8'h04, 4'd0,  12'h499, 4'd2},  // R2 high byte load
        '{OP_WR, 5'h1F, 8'h0E, 4'd15, 12'hE1F, 4'd1},  // R1 top channel
        '{OP_RD, 5'h00, 8'h00, 4'd15, 12'hE1F, 4'd3},  // R3 enter sim
        '{OP_WR, 5'h1E, 8'h66, 4'd15, 12'hE1F, 4'd3},  // R3
        '{OP_TK, 5'h00, 8'h00, 4'd15, 12'hE1F, 4'd5},  // R5 tick ignored
        '{OP_RD, 5'h05, 8'h00, 4'd15, 12'hE1F, 4'd5},  // R5 enable only
        '{OP_TK, 5'h00, 8'h00, 4'd15, 12'hE66, 4'd5},  // R5 tick loads
        '{OP_RD, 5'h06, 8'h00, 4'd15, 12'hE66, 4'd5},  // R5 disable
        '{OP_WR, 5'h1E, 8'h01, 4'd15, 12'hE66, 4'd5},  // R5
        '{OP_TK, 5'h00, 8'h00, 4'd15, 12'hE66, 4'd5},  // R5 tick ignored again
        '{OP_RD, 5'h0A, 8'h00, 4'd15, 12'hE01, 4'd4},  // R4 auto update
        '{OP_WR, 5'h03, 8'h08, 4'd1,  12'h811, 4'd4},  // R4 now automatic
        '{OP_RD, 5'h07, 8'h00, 4'd1,  12'h811, 4'd9},  // R9 unlisted read
        '{OP_RD, 5'h1D, 8'h00, 4'd1,  12'h811, 4'd9},  // R9 unlisted read
        '{OP_WR, 5'h03, 8'h09, 4'd1,  12'h911, 4'd9}   // R9 still automatic
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        bus_ofs = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0, tick = 1'b0;
    logic [NCH*DW-1:0] dac_out;
    logic              out_limit, irq;

    logic [4:0]        ofs8 = '0;
    logic              wr8 = 1'b0, rd8 = 1'b0;
    logic [8*DW-1:0]   dac_out8;
    logic              lim8, irq8;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_update_ctrl #(.NCH(NCH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_ofs(bus_ofs), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .tick(tick),
        .dac_out(dac_out), .out_limit(out_limit), .irq(irq));

    dac_update_ctrl #(.NCH(8), .DW(DW)) uut8 (
        .clk(clk), .rst_n(rst_n), .bus_ofs(ofs8), .bus_wdata(bus_wdata),
        .bus_wr(wr8), .bus_rd(rd8), .tick(1'b0),
        .dac_out(dac_out8), .out_limit(lim8), .irq(irq8));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] ch_word(input int n);
        return dac_out[n*DW +: DW];
    endfunction

    // One cycle of stimulus, driven at a falling edge and released after.
    task automatic cyc(input logic wr, input logic rd, input logic tk,
                       input logic [4:0] ofs, input logic [7:0] data);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; tick = tk; bus_ofs = ofs; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; tick = 1'b0;
    endtask

    task automatic cyc8(input logic wr, input logic rd,
                        input logic [4:0] ofs, input logic [7:0] data);
        @(negedge clk);
        wr8 = wr; rd8 = rd; ofs8 = ofs; bus_wdata = data;
        @(negedge clk);
        wr8 = 1'b0; rd8 = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8 limit", 32'(out_limit), 32'd1);
        check("R8 irq", 32'(irq), 32'd0);
        check("R8 ch0", 32'(ch_word(0)), 32'd0);
        check("R8 ch15", 32'(ch_word(15)), 32'd0);
        cyc(0, 0, 1, 5'h00, 8'h00);
        check("R8 irq disabled", 32'(irq), 32'd0);
        check("R8 timer disabled", 32'(ch_word(0)), 32'd0);

        // Fill every pre-load register: word n = {n, 0x10+n}; upper nibble A ignored.
        for (int n = 0; n < NCH; n++) begin
            cyc(1, 0, 0, 5'(2*n), 8'(8'h10 + n));
            cyc(1, 0, 0, 5'(2*n+1), 8'(8'hA0 | n));
        end
        check("R3 sim at reset", 32'(ch_word(7)), 32'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            cyc(v.op == OP_WR, v.op == OP_RD, v.op == OP_TK, v.ofs, v.data);
            checks++;
            if (ch_word(int'(v.ch)) !== v.exp) begin
                errors++;
                $display("FAIL R%0d vector %0d actual %0h expected %0h",
                         v.req, i, ch_word(int'(v.ch)), v.exp);
            end
        end

        // R7 restrict flag, outputs untouched
        cyc(0, 1, 0, 5'h0F, 8'h00);
        check("R7 clear", 32'(out_limit), 32'd0);
        cyc(0, 1, 0, 5'h0E, 8'h00);
        check("R7 set", 32'(out_limit), 32'd1);
        cyc(0, 1, 0, 5'h0F, 8'h00);
        check("R7 clear again", 32'(out_limit), 32'd0);
        check("R7 output kept", 32'(ch_word(1)), 32'h911);

        // R6 interrupt
        cyc(0, 1, 0, 5'h03, 8'h00);
        check("R6 no spurious", 32'(irq), 32'd0);
        cyc(0, 0, 1, 5'h00, 8'h00);
        check("R6 tick sets", 32'(irq), 32'd1);
        repeat (3) @(negedge clk);
        check("R6 level held", 32'(irq), 32'd1);
        cyc(0, 1, 0, 5'h04, 8'h00);
        check("R6 disable keeps pending", 32'(irq), 32'd1);
        cyc(0, 1, 0, 5'h03, 8'h00);
        check("R6 ack clears", 32'(irq), 32'd0);
        cyc(0, 1, 0, 5'h04, 8'h00);
        cyc(0, 0, 1, 5'h00, 8'h00);
        check("R6 disabled tick", 32'(irq), 32'd0);
        cyc(0, 1, 0, 5'h03, 8'h00);
        cyc(0, 0, 1, 5'h00, 8'h00);
        check("R6 set again", 32'(irq), 32'd1);
        // R10 tick and acknowledge in one cycle: set wins
        cyc(0, 1, 1, 5'h03, 8'h00);
        check("R10 set beats ack", 32'(irq), 32'd1);
        cyc(0, 1, 0, 5'h03, 8'h00);
        check("R6 final ack", 32'(irq), 32'd0);

        // R10 high-byte write and tick in one cycle
        cyc(0, 1, 0, 5'h00, 8'h00);
        cyc(0, 1, 0, 5'h05, 8'h00);
        cyc(1, 0, 0, 5'h04, 8'h44);
        check("R10 sim hold", 32'(ch_word(2)), 32'h212);
        cyc(1, 0, 1, 5'h05, 8'h07);
        check("R10 merged word", 32'(ch_word(2)), 32'h744);
        check("R10 other channel", 32'(ch_word(0)), 32'h499);

        // R9 eight-channel instance: offsets 16..31 write nothing
        cyc8(0, 1, 5'h02, 8'h00);
        cyc8(1, 0, 5'h10, 8'h5A);
        cyc8(1, 0, 5'h11, 8'h03);
        cyc8(1, 0, 5'h1F, 8'h0C);
        check("R9 no write past last channel", 32'(dac_out8 == '0), 32'd1);
        cyc8(1, 0, 5'h0E, 8'h5A);
        cyc8(1, 0, 5'h0F, 8'h03);
        check("R9 last channel writable", 32'(dac_out8[7*DW +: DW]), 32'h35A);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule